// File: doc/BRIEF.md
# SPI FIFO Event and Interrupt Unit

This unit sits between a 32-bit register bus and the serial shifter of an SPI master. It holds one byte-wide transmit queue and one byte-wide receive queue, each 32 bytes deep. Software pushes whole 32-bit words into the transmit queue. It drains the receive queue either a word at a time or a byte at a time, so a transfer whose length is not a multiple of four can still be emptied. The shifter side is a plain byte interface. It requests a byte from the transmit queue and offers received bytes to the receive queue.

A status word reports both fill levels and a set of sticky event flags. Two flags are level events derived from programmable thresholds. Four flags record refused pushes and pops. Software clears flags by writing ones. A mask register selects which flags drive the interrupt line, and that line is registered.

Register select (`busAddr`): 0 = mode (thresholds), 1 = event/status, 2 = interrupt mask, 3 = transmit data (write), 4 = receive data (read). Register reads are combinational in the cycle of `busRdEn`. A pop takes effect at the clock edge that ends that cycle.

Top module: `spi_fifo_evt`

## Requirements
- R1: After reset the mode register reads 0x00000403, the mask reads 0 and `irq` is 0. One cycle after reset is released, the event register reads 0x00000100.
- R2: The event word reports the receive fill count in bytes in bits 29:24 and the transmit fill count in bits 21:16. Both counts are live and can reach 32.
- R3: A write to register 3 pushes four bytes into the transmit queue, with bits 31:24 first. `shTxByte` always shows the oldest byte, and `shTxReq` removes it.
- R4: `shRxValid` appends `shRxData` to the receive queue. A word read of register 4 (`busByte`=0) returns the oldest byte in bits 31:24 and the next ones below it, then pops four. A byte read (`busByte`=1) returns the oldest byte in bits 7:0 with zeros above it, then pops one.
- R5: Event bit 9 is set on each clock edge where the receive count is greater than the receive threshold (mode bits 5:0).
- R6: Event bit 8 is set on each clock edge where the transmit count is less than or equal to the transmit threshold (mode bits 13:8).
- R7: Writing register 1 clears the event bits at the positions written as one. A bit whose set condition also holds in that cycle stays 1. Event bits are otherwise sticky.
- R8: A transmit push that finds fewer than 4 free bytes is dropped whole and sets event bit 1. A shifter byte offered to a full receive queue is dropped and sets event bit 3.
- R9: A receive read that finds fewer bytes than it needs pops nothing, returns 0 and sets event bit 2. A shifter request to an empty transmit queue pops nothing and sets event bit 0.
- R10: The mask register keeps only bits 9, 8 and 3:0. `irq` equals the OR of (event AND mask) as it stood in the previous cycle.
- R11: The mode register keeps only bits 13:8 and 5:0. All other bits read as 0.
- R12: All space checks use the fill counts from before the clock edge. A push and a pop on the same queue in the same cycle are both applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | 3 | Register select |
| busByte | input | 1 | Byte-wide access (receive data reads only) |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Read data, valid in the read cycle |
| shTxReq | input | 1 | Shifter takes one transmit byte |
| shTxByte | output | 8 | Oldest transmit byte |
| shRxValid | input | 1 | Shifter delivers one received byte |
| shRxData | input | 8 | Received byte |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is a receive queue sitting at exactly 32 bytes while the shifter offers a byte and the bus pops one in the same cycle. In that cycle the push must be refused against the old count while the pop still succeeds. The stimulus fills the queue one byte past full, clears the flags, and then fires both strokes in a single cycle. A similar directed step holds the transmit queue at a threshold edge and clears the level flag there. A long random phase then mixes all strokes against a queue-based reference model that is compared on every clock.

// File: rtl/spi_fifo_evt_pkg.sv
package spi_fifo_evt_pkg;

  typedef enum logic [2:0] {
    A_MODE = 3'd0,
    A_EVT  = 3'd1,
    A_MASK = 3'd2,
    A_TXD  = 3'd3,
    A_RXD  = 3'd4
  } regSel_e;

  // event word bit positions
  localparam int EV_RXLVL = 9;
  localparam int EV_TXLVL = 8;
  localparam int EV_RXOVF = 3;
  localparam int EV_RXUNF = 2;
  localparam int EV_TXOVF = 1;
  localparam int EV_TXUNF = 0;
  localparam logic [31:0] EV_KEEP = 32'h0000_030F;

  // count fields in the event word
  localparam int RXCNT_LSB = 24;
  localparam int TXCNT_LSB = 16;
  localparam int CNT_FIELD_W = 6;

  // threshold fields in the mode word
  localparam int TXTHR_LSB = 8;
  localparam int RXTHR_LSB = 0;
  localparam int THR_W = 6;

  typedef struct packed {
    logic    modeWr;
    logic    maskWr;
    logic    evtClr;
    logic    txPush;
    logic    txPop;
    logic    rxPush;
    logic [2:0] rxPopN;
    logic    txOvf;
    logic    txUnf;
    logic    rxOvf;
    logic    rxUnf;
    regSel_e rdSel;
  } ctrlStrb_t;

endpackage

// File: rtl/spi_fifo_evt_fifo.sv
module spi_fifo_evt_fifo #(
  parameter int DEPTH = 32,
  parameter int LANES = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1,
  localparam int N_W = $clog2(LANES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [N_W-1:0]     pushN,
  input  logic [LANES*8-1:0] pushData,
  input  logic [N_W-1:0]     popN,
  output logic [LANES*8-1:0] peekData,
  output logic [CNT_W-1:0]   count
);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (N_W'(i) < pushN) mem[wrPtr + PTR_W'(i)] <= pushData[8*i +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      wrPtr <= wrPtr + PTR_W'(pushN);
      rdPtr <= rdPtr + PTR_W'(popN);
      cnt   <= cnt + CNT_W'(pushN) - CNT_W'(popN);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_peek
    assign peekData[8*g +: 8] = mem[rdPtr + PTR_W'(g)];
  end

  assign count = cnt;

endmodule

// File: rtl/spi_fifo_evt_ctrl.sv
module spi_fifo_evt_ctrl
  import spi_fifo_evt_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LANES = 4,
  localparam int CNT_W = $clog2(DEPTH) + 1,
  localparam int N_W = $clog2(LANES + 1)
) (
  input  logic             busWrEn,
  input  logic             busRdEn,
  input  logic [2:0]       busAddr,
  input  logic             busByte,
  input  logic             shTxReq,
  input  logic             shRxValid,
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] rxCount,
  output ctrlStrb_t        strb
);

  regSel_e sel;
  logic [N_W-1:0] need;
  logic txRoom;

  assign sel    = regSel_e'(busAddr);
  assign need   = busByte ? N_W'(1) : N_W'(LANES);
  assign txRoom = txCount <= CNT_W'(DEPTH - LANES);

  always_comb begin
    strb = '0;
    strb.rdSel = sel;
    if (busWrEn) begin
      case (sel)
        A_MODE: strb.modeWr = 1'b1;
        A_EVT:  strb.evtClr = 1'b1;
        A_MASK: strb.maskWr = 1'b1;
        A_TXD: begin
          strb.txPush = txRoom;
          strb.txOvf  = !txRoom;
        end
        default: ;
      endcase
    end
    if (busRdEn && sel == A_RXD) begin
      if (rxCount >= CNT_W'(need)) strb.rxPopN = 3'(need);
      else                         strb.rxUnf  = 1'b1;
    end
    if (shTxReq) begin
      strb.txPop = txCount != '0;
      strb.txUnf = txCount == '0;
    end
    if (shRxValid) begin
      strb.rxPush = rxCount < CNT_W'(DEPTH);
      strb.rxOvf  = rxCount >= CNT_W'(DEPTH);
    end
  end

endmodule

// File: rtl/spi_fifo_evt_dp.sv
module spi_fifo_evt_dp
  import spi_fifo_evt_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int BUS_W = 32,
  parameter int TX_THR_RST = 4,
  parameter int RX_THR_RST = 3,
  localparam int LANES = BUS_W / 8,
  localparam int CNT_W = $clog2(DEPTH) + 1,
  localparam int N_W = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [BUS_W-1:0] busWData,
  input  logic [7:0]       shRxData,
  output logic [BUS_W-1:0] busRData,
  output logic [7:0]       shTxByte,
  output logic             irq,
  output logic [CNT_W-1:0] txCount,
  output logic [CNT_W-1:0] rxCount,
  output logic [31:0]      evtBits,
  output logic [31:0]      maskBits
);

  logic [LANES*8-1:0] txPushData;
  logic [LANES*8-1:0] txPeek;
  logic [LANES*8-1:0] rxPushData;
  logic [LANES*8-1:0] rxPeek;
  logic [N_W-1:0]     txPushN;
  logic [N_W-1:0]     txPopN;
  logic [N_W-1:0]     rxPushN;
  logic [N_W-1:0]     rxPopN;

  // word bytes enter the queue high byte first
  for (genvar g = 0; g < LANES; g++) begin : g_txLane
    assign txPushData[8*g +: 8] = busWData[BUS_W-1-8*g -: 8];
  end
  assign rxPushData = {{((LANES-1)*8){1'b0}}, shRxData};

  assign txPushN = strb.txPush ? N_W'(LANES) : '0;
  assign txPopN  = strb.txPop  ? N_W'(1) : '0;
  assign rxPushN = strb.rxPush ? N_W'(1) : '0;
  assign rxPopN  = N_W'(strb.rxPopN);

  spi_fifo_evt_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_txFifo (
    .clk(clk), .rstN(rstN), .pushN(txPushN), .pushData(txPushData),
    .popN(txPopN), .peekData(txPeek), .count(txCount)
  );

  spi_fifo_evt_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_rxFifo (
    .clk(clk), .rstN(rstN), .pushN(rxPushN), .pushData(rxPushData),
    .popN(rxPopN), .peekData(rxPeek), .count(rxCount)
  );

  assign shTxByte = txPeek[7:0];

  // mode, mask, event registers
  logic [THR_W-1:0] txThr;
  logic [THR_W-1:0] rxThr;
  logic [31:0]      maskReg;
  logic [31:0]      evtReg;
  logic [31:0]      evtSet;
  logic [31:0]      evtClrMask;
  logic             irqQ;

  always_comb begin
    evtSet = '0;
    evtSet[EV_RXLVL] = 32'(rxCount) > 32'(rxThr);
    evtSet[EV_TXLVL] = 32'(txCount) <= 32'(txThr);
    evtSet[EV_RXOVF] = strb.rxOvf;
    evtSet[EV_RXUNF] = strb.rxUnf;
    evtSet[EV_TXOVF] = strb.txOvf;
    evtSet[EV_TXUNF] = strb.txUnf;
    evtClrMask = strb.evtClr ? busWData[31:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txThr   <= THR_W'(TX_THR_RST);
      rxThr   <= THR_W'(RX_THR_RST);
      maskReg <= '0;
      evtReg  <= '0;
      irqQ    <= 1'b0;
    end else begin
      if (strb.modeWr) begin
        txThr <= busWData[TXTHR_LSB +: THR_W];
        rxThr <= busWData[RXTHR_LSB +: THR_W];
      end
      if (strb.maskWr) maskReg <= busWData[31:0] & EV_KEEP;
      evtReg <= ((evtReg & ~evtClrMask) | evtSet) & EV_KEEP;
      irqQ   <= |(evtReg & maskReg);
    end
  end

  // read return
  logic [BUS_W-1:0] modeWord;
  logic [BUS_W-1:0] evtWord;
  logic [BUS_W-1:0] rxWord;

  always_comb begin
    modeWord = '0;
    modeWord[TXTHR_LSB +: THR_W] = txThr;
    modeWord[RXTHR_LSB +: THR_W] = rxThr;
    evtWord = BUS_W'(evtReg);
    evtWord[RXCNT_LSB +: CNT_FIELD_W] = CNT_FIELD_W'(rxCount);
    evtWord[TXCNT_LSB +: CNT_FIELD_W] = CNT_FIELD_W'(txCount);
    rxWord = '0;
    if (rxPopN == N_W'(LANES)) begin
      for (int i = 0; i < LANES; i++) rxWord[BUS_W-1-8*i -: 8] = rxPeek[8*i +: 8];
    end else if (rxPopN == N_W'(1)) begin
      rxWord[7:0] = rxPeek[7:0];
    end
  end

  always_comb begin
    case (strb.rdSel)
      A_MODE:  busRData = modeWord;
      A_EVT:   busRData = evtWord;
      A_MASK:  busRData = BUS_W'(maskReg);
      A_RXD:   busRData = rxWord;
      default: busRData = '0;
    endcase
  end

  assign irq      = irqQ;
  assign evtBits  = evtReg;
  assign maskBits = maskReg;

endmodule

// File: rtl/spi_fifo_evt.sv
module spi_fifo_evt
  import spi_fifo_evt_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int TX_THR_RST = 4,
  parameter int RX_THR_RST = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic        busRdEn,
  input  logic [2:0]  busAddr,
  input  logic        busByte,
  input  logic [31:0] busWData,
  output logic [31:0] busRData,
  input  logic        shTxReq,
  output logic [7:0]  shTxByte,
  input  logic        shRxValid,
  input  logic [7:0]  shRxData,
  output logic        irq
);

  localparam int BUS_W = 32;
  localparam int LANES = BUS_W / 8;
  localparam int CNT_W = $clog2(DEPTH) + 1;

  ctrlStrb_t        strb;
  logic [CNT_W-1:0] txCount;
  logic [CNT_W-1:0] rxCount;
  logic [31:0]      evtBits;
  logic [31:0]      maskBits;

  spi_fifo_evt_ctrl #(.DEPTH(DEPTH), .LANES(LANES)) u_ctrl (
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr), .busByte(busByte),
    .shTxReq(shTxReq), .shRxValid(shRxValid), .txCount(txCount), .rxCount(rxCount),
    .strb(strb)
  );

  spi_fifo_evt_dp #(
    .DEPTH(DEPTH), .BUS_W(BUS_W), .TX_THR_RST(TX_THR_RST), .RX_THR_RST(RX_THR_RST)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWData(busWData), .shRxData(shRxData),
    .busRData(busRData), .shTxByte(shTxByte), .irq(irq), .txCount(txCount),
    .rxCount(rxCount), .evtBits(evtBits), .maskBits(maskBits)
  );

endmodule

// File: rtl/spi_fifo_evt_chk.sv
module spi_fifo_evt_chk
  import spi_fifo_evt_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             busWrEn,
  input logic             busRdEn,
  input logic [2:0]       busAddr,
  input logic             busByte,
  input logic [31:0]      busWData,
  input logic             shRxValid,
  input logic             irq,
  input logic [CNT_W-1:0] txCount,
  input logic [CNT_W-1:0] rxCount,
  input logic [31:0]      evtBits,
  input logic [31:0]      maskBits
);

  // R2: fill counts stay within the queue depth
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    (txCount <= CNT_W'(DEPTH)) && (rxCount <= CNT_W'(DEPTH)));

  // R8: a refused word push never grows the transmit queue and flags overflow
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == A_TXD && txCount > CNT_W'(DEPTH - 4))
    |=> (evtBits[EV_TXOVF] && txCount <= $past(txCount)));

  // R9: a word read short of four bytes flags underflow
  p_rx_underflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == A_RXD && !busByte && rxCount < CNT_W'(4))
    |=> evtBits[EV_RXUNF]);

  // R12: an accepted shifter byte with no bus read grows the receive queue by one
  p_rx_grow_r12: assert property (@(posedge clk) disable iff (!rstN)
    (shRxValid && rxCount < CNT_W'(DEPTH) && !busRdEn)
    |=> rxCount == $past(rxCount) + CNT_W'(1));

  // R7: a sticky flag survives any cycle that does not write one to it
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (evtBits[EV_RXOVF] && !(busWrEn && busAddr == A_EVT && busWData[EV_RXOVF]))
    |=> evtBits[EV_RXOVF]);

  // R10: the interrupt follows masked events one cycle later
  p_irq_latency_r10: assert property (@(posedge clk) disable iff (!rstN)
    irq == $past(|(evtBits & maskBits)));

  // R10: only the defined mask bits can hold
  p_mask_bits_r10: assert property (@(posedge clk) disable iff (!rstN)
    (maskBits & ~EV_KEEP) == '0);

endmodule

bind spi_fifo_evt spi_fifo_evt_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
  .busByte(busByte), .busWData(busWData), .shRxValid(shRxValid), .irq(irq),
  .txCount(txCount), .rxCount(rxCount), .evtBits(evtBits), .maskBits(maskBits)
);

// File: tb/spi_fifo_evt_tb.sv
`timescale 1ns/1ps
module spi_fifo_evt_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busByte = 1'b0;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;
  logic        shTxReq = 1'b0;
  logic [7:0]  shTxByte;
  logic        shRxValid = 1'b0;
  logic [7:0]  shRxData = '0;
  logic        irq;

  always #2 clk = ~clk;

  spi_fifo_evt u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busByte(busByte), .busWData(busWData), .busRData(busRData), .shTxReq(shTxReq),
    .shTxByte(shTxByte), .shRxValid(shRxValid), .shRxData(shRxData), .irq(irq)
  );

  int checks = 0;
  int fails = 0;
  bit run = 1'b0;
  bit done = 1'b0;

  // ---------------- reference model ----------------
  logic [7:0]  txq[$];
  logic [7:0]  rxq[$];
  logic [31:0] mEv;
  logic [31:0] mMask;
  logic [5:0]  mTxThr;
  logic [5:0]  mRxThr;
  logic        mIrq;
  int          tN;
  int          rN;
  int          need;
  logic [31:0] mSet;
  logic [31:0] mClr;
  logic        mIrqN;

  always @(posedge clk) begin
    if (!rstN) begin
      txq.delete(); rxq.delete();
      mEv = 0; mMask = 0; mTxThr = 6'd4; mRxThr = 6'd3; mIrq = 0;
    end else begin
      tN = txq.size(); rN = rxq.size();
      mSet = 0; mClr = 0;
      mIrqN = |(mEv & mMask);
      mSet[9] = rN > int'(mRxThr);
      mSet[8] = tN <= int'(mTxThr);
      if (shTxReq) begin
        if (tN > 0) void'(txq.pop_front()); else mSet[0] = 1'b1;
      end
      if (busWrEn) begin
        case (busAddr)
          3'd0: begin mTxThr = busWData[13:8]; mRxThr = busWData[5:0]; end
          3'd1: mClr = busWData;
          3'd2: mMask = busWData & 32'h30F;
          3'd3: begin
            if (tN <= 28) begin
              txq.push_back(busWData[31:24]); txq.push_back(busWData[23:16]);
              txq.push_back(busWData[15:8]);  txq.push_back(busWData[7:0]);
            end else mSet[1] = 1'b1;
          end
          default: ;
        endcase
      end
      if (busRdEn && busAddr == 3'd4) begin
        need = busByte ? 1 : 4;
        if (rN >= need) begin
          for (int k = 0; k < need; k++) void'(rxq.pop_front());
        end else mSet[2] = 1'b1;
      end
      if (shRxValid) begin
        if (rN < 32) rxq.push_back(shRxData); else mSet[3] = 1'b1;
      end
      mEv = ((mEv & ~mClr) | mSet) & 32'h30F;
      mIrq = mIrqN;
    end
  end

  function automatic logic [31:0] mRead(input logic [2:0] a, input logic b);
    logic [31:0] w;
    w = 0;
    case (a)
      3'd0: begin w[13:8] = mTxThr; w[5:0] = mRxThr; end
      3'd1: begin w = mEv; w[29:24] = 6'(rxq.size()); w[21:16] = 6'(txq.size()); end
      3'd2: w = mMask;
      3'd4: begin
        if (b) begin
          if (rxq.size() >= 1) w[7:0] = rxq[0];
        end else if (rxq.size() >= 4) begin
          w = {rxq[0], rxq[1], rxq[2], rxq[3]};
        end
      end
      default: w = 0;
    endcase
    return w;
  endfunction

  // ---------------- check helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // per-clock comparison of the outputs that depend only on state
  always @(negedge clk) begin
    if (rstN && run && !done) begin
      chk("R10 irq", 32'(irq), 32'(mIrq));
      if (txq.size() > 0) chk("R3 shTxByte", 32'(shTxByte), 32'(txq[0]));
    end
  end

  // each task occupies one cycle, starting and ending just after a falling edge
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic b, input string req,
                    input bit useLit, input logic [31:0] lit);
    busRdEn = 1'b1; busAddr = a; busByte = b;
    #1;
    if (useLit) chk(req, busRData, lit);
    else        chk(req, busRData, mRead(a, b));
    @(negedge clk);
    busRdEn = 1'b0; busByte = 1'b0;
  endtask

  task automatic rxIn(input logic [7:0] d);
    shRxValid = 1'b1; shRxData = d;
    @(negedge clk);
    shRxValid = 1'b0;
  endtask

  task automatic txOut(input logic [7:0] exp);
    chk("R3 byte order", 32'(shTxByte), 32'(exp));
    shTxReq = 1'b1;
    @(negedge clk);
    shTxReq = 1'b0;
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    run = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd1, 0, "R1 event after reset", 1, 32'h0000_0100);
    rd(3'd0, 0, "R1 mode after reset", 1, 32'h0000_0403);
    rd(3'd2, 0, "R1 mask after reset", 1, 32'h0000_0000);
    chk("R1 irq after reset", 32'(irq), 32'd0);

    // R11 mode field retention
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, 0, "R11 mode keeps only thresholds", 1, 32'h0000_3F3F);
    wr(3'd0, 32'h0000_0403);

    // R3 / R2 transmit word order and count field
    wr(3'd3, 32'hA1B2_C3D4);
    rd(3'd1, 0, "R2 tx count field", 1, 32'h0004_0100);
    txOut(8'hA1); txOut(8'hB2); txOut(8'hC3); txOut(8'hD4);

    // R7 clearing a bit whose condition still holds
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, 0, "R7 held level bit stays", 1, 32'h0000_0100);

    // R4 / R5 receive path, word and byte reads
    rxIn(8'h11); rxIn(8'h22); rxIn(8'h33); rxIn(8'h44); rxIn(8'h55); rxIn(8'h66);
    rd(3'd1, 0, "R5 rx level and R2 rx count", 1, 32'h0600_0300);
    rd(3'd4, 0, "R4 word read", 1, 32'h1122_3344);
    rd(3'd4, 1, "R4 byte read", 1, 32'h0000_0055);
    rd(3'd4, 1, "R4 byte read last", 1, 32'h0000_0066);
    rd(3'd1, 0, "R7 sticky after drain", 1, 32'h0000_0300);
    wr(3'd1, 32'h0000_0200);
    rd(3'd1, 0, "R7 clear of a released bit", 1, 32'h0000_0100);

    // R10 mask and interrupt latency
    wr(3'd2, 32'hFFFF_FFFF);
    chk("R10 irq one cycle late", 32'(irq), 32'd0);
    idle(1);
    chk("R10 irq raised", 32'(irq), 32'd1);
    rd(3'd2, 0, "R10 mask bits kept", 1, 32'h0000_030F);
    wr(3'd2, 32'h0);
    idle(1);
    chk("R10 irq dropped", 32'(irq), 32'd0);

    // R8 transmit overflow
    for (int k = 0; k < 8; k++) wr(3'd3, {8'(k), 8'(k + 16), 8'(k + 32), 8'(k + 48)});
    wr(3'd3, 32'hDEAD_BEEF);
    rd(3'd1, 0, "R8 tx overflow", 1, 32'h0020_0102);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, 0, "R6 full tx clears level", 1, 32'h0020_0000);
    for (int k = 0; k < 32; k++) begin
      shTxReq = 1'b1; @(negedge clk);
    end
    shTxReq = 1'b0;
    idle(1);

    // R8 receive overflow
    for (int k = 0; k < 33; k++) rxIn(8'(k + 8'h40));
    rd(3'd1, 0, "R8 rx overflow", 1, 32'h2000_0308);

    // R12 full receive queue: push and pop in one cycle
    wr(3'd1, 32'hFFFF_FFFF);
    shRxValid = 1'b1; shRxData = 8'hEE;
    rd(3'd4, 1, "R12 pop on full queue", 1, 32'h0000_0040);
    shRxValid = 1'b0;
    rd(3'd1, 0, "R12 push refused on old count", 1, 32'h1F00_0308);

    // R9 underflows
    for (int k = 0; k < 7; k++) rd(3'd4, 0, "R4 drain word", 0, 32'h0);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd4, 0, "R9 short word read returns 0", 1, 32'h0000_0000);
    rd(3'd1, 0, "R9 rx underflow", 1, 32'h0300_0104);
    shTxReq = 1'b1; @(negedge clk); shTxReq = 1'b0;
    rd(3'd1, 0, "R9 tx underflow", 1, 32'h0300_0105);

    // R6 transmit threshold
    wr(3'd0, 32'h0000_0803);
    for (int k = 0; k < 3; k++) wr(3'd3, 32'h0102_0304);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, 0, "R6 above threshold", 1, 32'h030C_0000);
    for (int k = 0; k < 4; k++) begin
      shTxReq = 1'b1; @(negedge clk);
    end
    shTxReq = 1'b0;
    idle(1);
    rd(3'd1, 0, "R6 at threshold", 1, 32'h0308_0100);

    // mixed random traffic against the model
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = int'($urandom_range(0, 99));
      shTxReq   = ($urandom_range(0, 99) < 30);
      shRxValid = ($urandom_range(0, 99) < 35);
      shRxData  = 8'($urandom);
      busWrEn = 1'b0; busRdEn = 1'b0; busByte = 1'b0;
      if (r < 12) begin
        busWrEn = 1'b1; busAddr = 3'd3; busWData = $urandom;
      end else if (r < 16) begin
        busWrEn = 1'b1; busAddr = 3'd1; busWData = $urandom;
      end else if (r < 18) begin
        busWrEn = 1'b1; busAddr = 3'd2; busWData = $urandom;
      end else if (r < 19) begin
        busWrEn = 1'b1; busAddr = 3'd0; busWData = $urandom;
      end else if (r < 40) begin
        busRdEn = 1'b1; busAddr = 3'd4; busByte = ($urandom_range(0, 1) == 1);
      end else if (r < 50) begin
        busRdEn = 1'b1; busAddr = 3'd1;
      end
      #1;
      if (busRdEn) chk("R4 R2 R12 random read", busRData, mRead(busAddr, busByte));
      @(negedge clk);
    end
    busWrEn = 1'b0; busRdEn = 1'b0; shTxReq = 1'b0; shRxValid = 1'b0;
    idle(2);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule